// File: doc/BRIEF.md
# I2C Target Register File

This block is an I2C target that gives a bus master byte-wide access to 256 internal configuration registers. SCL and SDA are sampled with the system clock, brought through two-flop synchronizers and a glitch filter, and then decoded into clock edges and START/STOP conditions. Its 7-bit address has the fixed upper six bits 110000. The last bit comes from a strap pin, so the block answers at 0x60 or at 0x61.

A write transaction carries a register address byte followed by any number of data bytes, and each data byte lands at the next register. A read uses a pointer that an earlier write transaction set, which may hold only the register address. The block returns consecutive registers until the master answers a byte with NACK. The pointer wraps from 0xFF to 0x00 and is kept between transactions. One register address is wired to a read-only status input and ignores writes. SDA is driven open-drain through an output-enable. If SCL stops moving in the middle of a transaction for longer than a programmable number of cycles, the engine drops back to idle and releases SDA.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal {110000, addr_lsb}; bit 0 of that byte selects read (1) or write (0).
- R2: An address byte that does not match gets no acknowledge, and the rest of that transaction neither changes a register nor drives SDA.
- R3: In a write transaction the first byte after the address loads the register pointer, and the following data byte, received MSB first, is stored at that address.
- R4: Each further data byte of a write burst goes to the next register address, and the pointer wraps from 0xFF to 0x00.
- R5: A read transaction returns the register at the current pointer MSB first, then the following registers while the master acknowledges. The pointer persists from one transaction to the next.
- R6: After a byte that the master answers with NACK, SDA stays released until the next START. The pointer has still advanced past that byte.
- R7: Register address STATUS_ADDR (default 0x80) reads the status_i input, and writes to it are dropped, though the pointer still advances.
- R8: A START or STOP that arrives before the eighth bit of a data byte abandons that byte without writing it.
- R9: A pulse on SCL shorter than FILT_LEN system-clock cycles (default 3) is not taken as a clock edge.
- R10: If SCL has no edge for TIMEOUT_CYC system-clock cycles during a transaction, the engine returns to idle and releases SDA. A later transaction then works normally.
- R11: After reset SDA is released and every register reads 0x00.
- R12: Transfers work at a slow bit rate (Standard-mode) as well as at a fast one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_lsb | input | 1 | Strap that sets bit 0 of the target address |
| status_i | input | 8 | Value returned by the read-only status register |

## Verification
A table of single register writes, each followed by a read-back, uses data with alternating bits, all ones, all zeros and edge bits. These separate a correct MSB-first shift from a reversed or stuck one. Bursts that start at 0xFE show whether the pointer wraps and whether it carries over into a later read that is not preceded by a pointer write. Address bytes sent under both strap levels show that the strap bit matches, and the following register contents show that a foreign transaction changed nothing. Further sequences each end a byte in a different way: a STOP or a repeated START mid-byte, a short SCL spike, a stalled SCL, and a slow bit rate. Each of these shows whether a byte was committed or dropped as required.

// File: rtl/i2c_regfile_target_pkg.sv
// Shared types and constants for the I2C target register file.
package i2c_regfile_target_pkg;

    // Fixed upper six bits of the 7-bit target address.
    localparam logic [5:0] DEV_ADDR_HI = 6'b110000;

    // Transaction engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } eng_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
// Brings one bus line into the clock domain and suppresses short pulses.
// Assumes the line idles high. The output follows the synchronized input only
// after FILT_LEN consecutive cycles that differ from the current output.
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Stability counter that decides when the filtered level may change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else if (sync_q[1] == line_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            cnt_q  <= '0;
            line_o <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_cond.sv
// Turns the filtered SCL and SDA levels into one-cycle event strobes:
// SCL rising and falling edges, START (SDA falls while SCL high) and
// STOP (SDA rises while SCL high). Assumes filtered, synchronous inputs.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Previous-cycle copies of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Event decoding.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_target_engine.sv
// Byte-level I2C target state machine. It shifts bits in on SCL rising
// edges and changes SDA only on SCL falling edges. It matches the address,
// handles the register pointer and issues write strobes. Assumes event strobes
// from i2c_bus_cond and read data that is valid in the same cycle.
module i2c_target_engine
    import i2c_regfile_target_pkg::*;
#(
    parameter int AW          = 8,
    parameter int TIMEOUT_CYC = 1_500_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_f,
    input  logic          addr_lsb,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output eng_state_t    state
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [7:0]    shreg;
    logic [7:0]    txd;
    logic [3:0]    bit_cnt;
    logic          ack_phase;
    logic          ack_own;
    logic          nack;
    logic [TW-1:0] tmo_cnt;
    logic          tmo_hit;
    logic          addr_match;

    assign tmo_hit    = (tmo_cnt == TW'(TIMEOUT_CYC - 1));
    assign addr_match = (shreg[7:1] == {DEV_ADDR_HI, addr_lsb});

    // Counts cycles without an SCL edge while a transaction is open.
    always_ff @(posedge clk) begin
        if (!rst_n || start_det || stop_det || state == ST_IDLE || scl_rise || scl_fall)
            tmo_cnt <= '0;
        else if (!tmo_hit)
            tmo_cnt <= tmo_cnt + 1'b1;
    end

    // Transaction sequencing, bit shifting, acknowledge and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            txd       <= '0;
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            ack_own   <= 1'b0;
            nack      <= 1'b0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state     <= ST_DEVADDR;
                bit_cnt   <= '0;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_det || tmo_hit) begin
                state     <= ST_IDLE;
                bit_cnt   <= '0;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (state != ST_IDLE && state != ST_SKIP) begin
                if (scl_rise) begin
                    if (ack_phase) begin
                        nack <= sda_f;
                    end else if (bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (ack_phase) begin
                        ack_phase <= 1'b0;
                        ack_own   <= 1'b0;
                        bit_cnt   <= '0;
                        sda_oe    <= 1'b0;
                        if (state == ST_READ) begin
                            if (ack_own || !nack) begin
                                txd    <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end else if (bit_cnt == 4'd8) begin
                        ack_phase <= 1'b1;
                        unique case (state)
                            ST_DEVADDR: begin
                                if (addr_match) begin
                                    ack_own <= 1'b1;
                                    sda_oe  <= 1'b1;
                                    state   <= shreg[0] ? ST_READ : ST_REGADDR;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                            ST_REGADDR: begin
                                ptr     <= shreg[AW-1:0];
                                ack_own <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WRITE;
                            end
                            ST_WRITE: begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                ack_own <= 1'b1;
                                sda_oe  <= 1'b1;
                            end
                            default: begin
                                ptr     <= ptr + 1'b1;
                                ack_own <= 1'b0;
                                sda_oe  <= 1'b0;
                            end
                        endcase
                    end else if (state == ST_READ && bit_cnt != 4'd0) begin
                        txd    <= {txd[6:0], 1'b0};
                        sda_oe <= ~txd[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_store.sv
// Register storage with one write port and one asynchronous read port.
// The location STATUS_ADDR is replaced on read by status_i and never written.
module i2c_reg_store #(
    parameter int          AW          = 8,
    parameter logic [7:0]  STATUS_ADDR = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    input  logic [7:0]    status_i,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Storage array with clear on reset and guarded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && waddr != STATUS_ADDR[AW-1:0]) begin
            mem[waddr] <= wdata;
        end
    end

    // Read mux that substitutes the status input.
    always_comb begin
        if (raddr == STATUS_ADDR[AW-1:0]) rdata = status_i;
        else                              rdata = mem[raddr];
    end
endmodule

// File: rtl/i2c_regfile_target.sv
// Top of the I2C target register file: line filters, bus event decoder,
// byte engine and register store. Assumes scl_i/sda_i are the resolved bus
// levels and that sda_oe drives an open-drain pull-down.
module i2c_regfile_target
    import i2c_regfile_target_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         FILT_LEN    = 3,
    parameter int         TIMEOUT_CYC = 1_500_000,
    parameter logic [7:0] STATUS_ADDR = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_lsb,
    input  logic [7:0] status_i
);
    logic [1:0]    raw_lines;
    logic [1:0]    filt_lines;
    logic          scl_f, sda_f;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;
    eng_state_t    eng_state;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = filt_lines[0];
    assign sda_f     = filt_lines[1];

    // One filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_engine #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_f     (sda_f),
        .addr_lsb  (addr_lsb),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .state     (eng_state)
    );

    i2c_reg_store #(.AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .raddr    (ptr),
        .status_i (status_i),
        .rdata    (rd_data)
    );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
// Protocol checker for i2c_regfile_target, attached with bind. It observes the
// SDA drive against the filtered SCL, the engine state and the write strobe.
module i2c_regfile_target_chk
    import i2c_regfile_target_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_f,
    input eng_state_t    eng_state,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] ptr
);
    // R10: an idle engine never holds SDA.
    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_state == ST_IDLE |-> !sda_oe);

    // R2: a skipped transaction never drives SDA.
    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_state == ST_SKIP |-> !sda_oe);

    // R3: the SDA drive changes only while SCL is low.
    p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R4: the pointer has moved one past the written location.
    p_ptr_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == AW'(wr_addr + 1'b1));

    // R3: writes are only issued from the data phase of a write.
    p_write_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> eng_state == ST_WRITE);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_i2c_regfile_target.sv
// Bench for i2c_regfile_target: a bit-banged master with an open-drain bus.
module test_i2c_regfile_target;
    localparam int TMO = 1000;
    localparam int NVEC = 6;
    // {register address, data}
    localparam logic [15:0] VEC [NVEC] = '{16'h05A5, 16'h065A, 16'h10FF,
                                           16'h1100, 16'h7F81, 16'h403C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       addr_lsb = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic       scl_i, sda_i;

    int  checks = 0;
    int  errors = 0;
    int  q = 15;
    bit  done = 1'b0;

    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    logic       wr_acked, rd_acked, extra_bit;

    assign scl_i = scl_m;
    assign sda_i = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regfile_target #(.TIMEOUT_CYC(TMO)) i_i2c_regfile_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_oe   (sda_oe),
        .addr_lsb (addr_lsb),
        .status_i (status_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hold(q);
        scl_m = 1'b1; hold(q);
        sda_m = 1'b0; hold(q);
        scl_m = 1'b0; hold(q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hold(q);
        scl_m = 1'b1; hold(q);
        sda_m = 1'b1; hold(q);
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; hold(q);
        scl_m = 1'b1; hold(q);
        s = sda_i; hold(q);
        scl_m = 1'b0; hold(q);
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic rx_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(nack, s);
    endtask

    // Write n bytes from wbuf starting at register ra.
    task automatic wr_burst(input logic [7:0] dev, input logic [7:0] ra, input int n);
        logic a;
        i2c_start();
        tx_byte(dev, a);
        wr_acked = a;
        tx_byte(ra, a);
        wr_acked &= a;
        for (int i = 0; i < n; i++) begin
            tx_byte(wbuf[i], a);
            wr_acked &= a;
        end
        i2c_stop();
    endtask

    task automatic set_ptr(input logic [7:0] dev, input logic [7:0] ra);
        logic a;
        i2c_start();
        tx_byte(dev, a);
        wr_acked = a;
        tx_byte(ra, a);
        wr_acked &= a;
        i2c_stop();
    endtask

    // Read n bytes into rbuf, NACK the last, clock one extra bit, then STOP.
    task automatic rd_burst(input logic [7:0] dev, input int n);
        logic a;
        i2c_start();
        tx_byte(dev | 8'h01, a);
        rd_acked = a;
        for (int i = 0; i < n; i++) rx_byte(i == n - 1, rbuf[i]);
        bit_io(1'b1, extra_bit);
        i2c_stop();
    endtask

    task automatic read_one(input logic [7:0] ra, output logic [7:0] d);
        set_ptr(8'hC0, ra);
        rd_burst(8'hC0, 1);
        d = rbuf[0];
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic a, s;
        hold(5);
        // R11: reset state
        chk("R11 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        hold(10);
        chk("R11 sda released after reset", sda_oe, 0);
        read_one(8'h20, d);
        chk("R11 register clear after reset", d, 8'h00);
        chk("R1 read address acked", rd_acked, 1);

        // R3/R5: vector table of single writes and read-backs
        for (int v = 0; v < NVEC; v++) begin
            wbuf[0] = VEC[v][7:0];
            wr_burst(8'hC0, VEC[v][15:8], 1);
            chk("R1 write transaction acked", wr_acked, 1);
            read_one(VEC[v][15:8], d);
            chk("R3 single write read back", d, VEC[v][7:0]);
        end

        // R2: foreign address 0x61 while strap is 0
        i2c_start();
        tx_byte(8'hC2, a);
        chk("R2 foreign address not acked", a, 0);
        tx_byte(8'h05, a);
        chk("R2 rest of foreign transaction not acked", a, 0);
        tx_byte(8'hEE, a);
        i2c_stop();
        read_one(8'h05, d);
        chk("R2 register untouched by foreign write", d, 8'hA5);

        // R1: strap set to 1 moves the address to 0x61
        addr_lsb = 1'b1;
        wbuf[0] = 8'h77;
        wr_burst(8'hC2, 8'h06, 1);
        chk("R1 strapped address acked", wr_acked, 1);
        addr_lsb = 1'b0;
        read_one(8'h06, d);
        chk("R1 strapped write landed", d, 8'h77);

        // R4: burst write across the wrap point
        wbuf = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_burst(8'hC0, 8'hFE, 4);
        chk("R4 burst write acked", wr_acked, 1);
        set_ptr(8'hC0, 8'hFE);
        rd_burst(8'hC0, 3);
        chk("R5 burst read byte 0", rbuf[0], 8'h11);
        chk("R4 burst read byte at 0xFF", rbuf[1], 8'h22);
        chk("R4 wrapped byte at 0x00", rbuf[2], 8'h33);
        chk("R6 sda released after NACK", extra_bit, 1);
        // R5/R6: pointer persists and advanced past the NACKed byte
        rd_burst(8'hC0, 1);
        chk("R6 pointer kept after NACK", rbuf[0], 8'h44);

        // R7: status register
        status_i = 8'hC3;
        read_one(8'h80, d);
        chk("R7 status read", d, 8'hC3);
        wbuf = '{8'hAA, 8'h00, 8'h55, 8'h00};
        wr_burst(8'hC0, 8'h7F, 3);
        status_i = 8'h5E;
        set_ptr(8'hC0, 8'h7F);
        rd_burst(8'hC0, 3);
        chk("R7 byte before status written", rbuf[0], 8'hAA);
        chk("R7 status not written", rbuf[1], 8'h5E);
        chk("R7 pointer advanced past status", rbuf[2], 8'h55);

        // R8: STOP mid-byte
        wbuf[0] = 8'h77;
        wr_burst(8'hC0, 8'h30, 1);
        i2c_start();
        tx_byte(8'hC0, a);
        tx_byte(8'h30, a);
        for (int i = 0; i < 4; i++) bit_io(1'b0, s);
        i2c_stop();
        read_one(8'h30, d);
        chk("R8 STOP mid-byte drops byte", d, 8'h77);
        // R8: repeated START mid-byte, then read from the set pointer
        wbuf[0] = 8'h39;
        wr_burst(8'hC0, 8'h31, 1);
        i2c_start();
        tx_byte(8'hC0, a);
        tx_byte(8'h31, a);
        for (int i = 0; i < 3; i++) bit_io(1'b0, s);
        i2c_start();
        tx_byte(8'hC1, a);
        chk("R8 repeated START address acked", a, 1);
        rx_byte(1'b1, d);
        i2c_stop();
        chk("R8 repeated START drops byte", d, 8'h39);

        // R9: short SCL spike during a data byte
        i2c_start();
        tx_byte(8'hC0, a);
        tx_byte(8'h50, a);
        for (int i = 7; i >= 4; i--) bit_io(wbuf[0][i] ^ 1'b0 ? 1'b1 : 1'b0, s);
        hold(2);
        scl_m = 1'b1; hold(2);
        scl_m = 1'b0; hold(q);
        for (int i = 3; i >= 0; i--) bit_io(wbuf[0][i], s);
        bit_io(1'b1, s);
        chk("R9 byte with spike acked", s, 0);
        i2c_stop();
        read_one(8'h50, d);
        chk("R9 spike ignored", d, 8'h39);

        // R10: stall SCL while the target drives a zero bit
        wbuf[0] = 8'h12;
        wr_burst(8'hC0, 8'h60, 1);
        set_ptr(8'hC0, 8'h60);
        i2c_start();
        tx_byte(8'hC1, a);
        hold(200);
        chk("R10 target drives during stall", sda_oe, 1);
        hold(TMO + 50);
        chk("R10 timeout releases sda", sda_oe, 0);
        i2c_stop();
        read_one(8'h60, d);
        chk("R10 normal transfer after timeout", d, 8'h12);

        // R12: slow bit rate
        q = 125;
        wbuf = '{8'h96, 8'h69, 8'h00, 8'h00};
        wr_burst(8'hC0, 8'h70, 2);
        chk("R12 slow write acked", wr_acked, 1);
        set_ptr(8'hC0, 8'h70);
        rd_burst(8'hC0, 2);
        chk("R12 slow read byte 0", rbuf[0], 8'h96);
        chk("R12 slow read byte 1", rbuf[1], 8'h69);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule